// File: doc/BRIEF.md
# USB Dual-Role Selection Controller

This block decides whether a dual-role USB controller acts as embedded host or as device. It takes the raw cable identification pin, passes it through a two-flop synchronizer, and accepts a new level only after the level has held for a programmable number of cycles. Software can replace the filtered pin level with a register value. The resulting effective identification level sets the role, and a new level is applied only while the bus reports idle.

Software can also ask the local side, while it is in the device role, to take over the host role. The request waits for the next bus idle period, then raises a busy indication so that external negotiation logic can run. That logic reports completion with a done pulse and a success flag. On success the role becomes host. On failure the role stays as it was and a sticky failure flag is set. In both cases the request bit clears itself. A small register interface exposes control, status and the debounce length.

Top module: `usb_role_ctrl`

## Requirements
- R1: After reset the role is device (`is_host_o`=0), `nego_busy_o`=0, the control register reads 0x00, the status register reads 0x08 (filtered ID high, no failure) and the debounce register reads the parameter `DEB_RST` (default 4).
- R2: An effective ID of 0 puts the block in the host role (`is_host_o`=1). An effective ID of 1 puts it in the device role.
- R3: The synchronized ID is accepted as the filtered ID only after it has differed from the current filtered value on N consecutive clock cycles, where N is the debounce register at address 2 (a value of 0 acts as 1). Shorter pulses do not change the filtered value.
- R4: When control bit 0 (override enable) is 1, control bit 1 (override value) replaces the filtered pin level as the effective ID. Pin changes then have no effect on the role.
- R5: A change of the effective ID is applied to the role only in a cycle with `bus_idle_i`=1. While the bus is busy the change waits.
- R6: Writing 1 to control bit 2 (host request) while in the device role starts a negotiation at the first cycle with `bus_idle_i`=1. `nego_busy_o` and status bit 1 are then 1 until `nego_done_i`.
- R7: `nego_done_i` with `nego_ok_i`=1 during a negotiation makes the role host, ends the negotiation and clears the host-request bit.
- R8: `nego_done_i` with `nego_ok_i`=0 during a negotiation leaves the role unchanged, clears the host-request bit and sets status bit 2 (failure). That bit stays set until software writes 1 to status bit 2.
- R9: A host request made while already in the host role is dropped at the next idle cycle, with no negotiation.
- R10: Register reads are combinational. Address 0 reads {host request, override value, override enable} in bits 2..0. Address 1 reads {filtered ID, failure, busy, role} in bits 3..0. Address 2 reads the debounce length. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_pin_i | input | 1 | Raw cable identification pin (asynchronous) |
| bus_idle_i | input | 1 | Bus is in an idle period |
| nego_done_i | input | 1 | Negotiation finished (one-cycle pulse) |
| nego_ok_i | input | 1 | Negotiation outcome, valid with `nego_done_i` |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| is_host_o | output | 1 | Current role: 1 host, 0 device |
| nego_busy_o | output | 1 | Negotiation in progress |

## Verification
The assertions assume that `nego_done_i` and `nego_ok_i` matter only while a negotiation is in progress, and that `bus_idle_i` is a clean synchronous level. The stimulus raises the done pulse only after it has seen `nego_busy_o` high, and it keeps the pulse to exactly one cycle. All inputs except the ID pin change on the falling edge. The ID pin is also driven there, so the synchronizer sees stable levels and the cycle-accurate model in the bench can track it exactly.

// File: rtl/role_pkg.sv
package role_pkg;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_DEB  = 2'd2,
        A_RSVD = 2'd3
    } reg_addr_e;

    typedef enum logic {
        S_STEADY = 1'b0,
        S_NEGO   = 1'b1
    } fsm_e;

    typedef struct packed {
        logic host_req;
        logic ovr_val;
        logic ovr_en;
    } ctrl_t;

    typedef struct packed {
        logic id_filt;
        logic fail;
        logic busy;
        logic is_host;
    } stat_t;

    function automatic logic pick_id(ctrl_t c, logic pin_id);
        return c.ovr_en ? c.ovr_val : pin_id;
    endfunction
endpackage

// File: rtl/id_filter.sv
module id_filter #(
    parameter int DEB_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  logic [DEB_W-1:0] deb_len_i,
    output logic             id_o
);
    localparam int SUM_W = DEB_W + 1;

    logic             sync_a, sync_b;
    logic [DEB_W-1:0] cnt;
    logic [SUM_W-1:0] cnt_next;
    logic             past_ok;

    assign cnt_next = {1'b0, cnt} + SUM_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a  <= 1'b1;
            sync_b  <= 1'b1;
            id_o    <= 1'b1;
            cnt     <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            sync_a  <= pin_i;
            sync_b  <= sync_a;
            if (sync_b == id_o) begin
                cnt <= '0;
            end else if (cnt_next >= {1'b0, deb_len_i}) begin
                id_o <= sync_b;
                cnt  <= '0;
            end else begin
                cnt <= cnt_next[DEB_W-1:0];
            end
        end
    end

    // R3: a newly accepted level is the level the synchronizer held
    assert_accept_matches_sync_R3: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !$stable(id_o) |-> (id_o == $past(sync_b)));
endmodule

// File: rtl/role_fsm.sv
module role_fsm
    import role_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic eff_id_i,
    input  logic bus_idle_i,
    input  logic host_req_i,
    input  logic nego_done_i,
    input  logic nego_ok_i,
    output logic is_host_o,
    output logic busy_o,
    output logic req_clr_o,
    output logic fail_set_o
);
    fsm_e st;
    logic applied_id;
    logic id_pend;
    logic past_ok;

    assign id_pend    = (eff_id_i != applied_id);
    assign busy_o     = (st == S_NEGO);
    assign fail_set_o = busy_o && nego_done_i && !nego_ok_i;
    assign req_clr_o  = (busy_o && nego_done_i) ||
                        (!busy_o && host_req_i && bus_idle_i && is_host_o && !id_pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_STEADY;
            is_host_o  <= 1'b0;
            applied_id <= 1'b1;
            past_ok    <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            case (st)
                S_STEADY: begin
                    if (id_pend && bus_idle_i) begin
                        is_host_o  <= ~eff_id_i;
                        applied_id <= eff_id_i;
                    end else if (host_req_i && bus_idle_i && !is_host_o) begin
                        st <= S_NEGO;
                    end
                end
                S_NEGO: begin
                    if (nego_done_i) begin
                        if (nego_ok_i) is_host_o <= 1'b1;
                        st <= S_STEADY;
                    end
                end
                default: st <= S_STEADY;
            endcase
        end
    end

    // R5: the role moves only after an idle cycle or a finished negotiation
    assert_change_at_idle_R5: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !$stable(is_host_o) |-> ($past(bus_idle_i) || $past(busy_o && nego_done_i)));
    // R6: a negotiation starts only from the device role during idle
    assert_nego_from_device_R6: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $rose(busy_o) |-> (!is_host_o && $past(bus_idle_i)));
    // R7: a successful negotiation leaves the block as host
    assert_success_host_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && nego_done_i && nego_ok_i) |=> (is_host_o && !busy_o));
    // R8: a failed negotiation keeps the role
    assert_fail_keeps_role_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && nego_done_i && !nego_ok_i) |=> ($stable(is_host_o) && !busy_o));
endmodule

// File: rtl/role_regs.sv
module role_regs
    import role_pkg::*;
#(
    parameter int          DEB_W   = 8,
    parameter logic [7:0]  DEB_RST = 8'd4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       addr_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             req_clr_i,
    input  logic             fail_set_i,
    input  logic             is_host_i,
    input  logic             busy_i,
    input  logic             id_filt_i,
    output ctrl_t            ctrl_o,
    output logic [DEB_W-1:0] deb_len_o,
    output logic [REG_W-1:0] rdata_o
);
    reg_addr_e a;
    logic      fail;
    stat_t     st;
    logic      wr_ctrl, wr_stat, wr_deb;

    assign a       = reg_addr_e'(addr_i);
    assign wr_ctrl = wr_i && (a == A_CTRL);
    assign wr_stat = wr_i && (a == A_STAT);
    assign wr_deb  = wr_i && (a == A_DEB);
    assign st      = '{id_filt: id_filt_i, fail: fail, busy: busy_i, is_host: is_host_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o    <= '0;
            fail      <= 1'b0;
            deb_len_o <= DEB_W'(DEB_RST);
        end else begin
            if (wr_ctrl) begin
                ctrl_o.ovr_en  <= wdata_i[0];
                ctrl_o.ovr_val <= wdata_i[1];
            end
            if (req_clr_i)                 ctrl_o.host_req <= 1'b0;
            else if (wr_ctrl && wdata_i[2]) ctrl_o.host_req <= 1'b1;
            if (fail_set_i)                fail <= 1'b1;
            else if (wr_stat && wdata_i[2]) fail <= 1'b0;
            if (wr_deb) deb_len_o <= wdata_i[DEB_W-1:0];
        end
    end

    always_comb begin
        case (a)
            A_CTRL:  rdata_o = REG_W'(ctrl_o);
            A_STAT:  rdata_o = REG_W'(st);
            A_DEB:   rdata_o = REG_W'(deb_len_o);
            default: rdata_o = '0;
        endcase
    end

    // R8: the failure flag is sticky until software clears it
    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (fail && !(wr_stat && wdata_i[2])) |=> fail);
    // R7: a completed or dropped request reads back as cleared
    assert_req_clears_R7: assert property (@(posedge clk) disable iff (rst)
        req_clr_i |=> !ctrl_o.host_req);
endmodule

// File: rtl/usb_role_ctrl.sv
module usb_role_ctrl
    import role_pkg::*;
#(
    parameter int         DEB_W   = 8,
    parameter logic [7:0] DEB_RST = 8'd4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       id_pin_i,
    input  logic       bus_idle_i,
    input  logic       nego_done_i,
    input  logic       nego_ok_i,
    input  logic [1:0] reg_addr_i,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       is_host_o,
    output logic       nego_busy_o
);
    ctrl_t            ctrl;
    logic [DEB_W-1:0] deb_len;
    logic             id_filt, eff_id, req_clr, fail_set;

    assign eff_id = pick_id(ctrl, id_filt);

    id_filter #(.DEB_W(DEB_W)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (id_pin_i),
        .deb_len_i (deb_len),
        .id_o      (id_filt)
    );

    role_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .eff_id_i    (eff_id),
        .bus_idle_i  (bus_idle_i),
        .host_req_i  (ctrl.host_req),
        .nego_done_i (nego_done_i),
        .nego_ok_i   (nego_ok_i),
        .is_host_o   (is_host_o),
        .busy_o      (nego_busy_o),
        .req_clr_o   (req_clr),
        .fail_set_o  (fail_set)
    );

    role_regs #(.DEB_W(DEB_W), .DEB_RST(DEB_RST)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (reg_addr_i),
        .wr_i       (reg_wr_i),
        .wdata_i    (reg_wdata_i),
        .req_clr_i  (req_clr),
        .fail_set_i (fail_set),
        .is_host_i  (is_host_o),
        .busy_i     (nego_busy_o),
        .id_filt_i  (id_filt),
        .ctrl_o     (ctrl),
        .deb_len_o  (deb_len),
        .rdata_o    (reg_rdata_o)
    );
endmodule

// File: tb/usb_role_ctrl_tb.sv
module usb_role_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       id_pin = 1'b1, idle = 1'b1, done = 1'b0, ok = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       is_host, busy;

    int checks = 0, failures = 0;
    bit finished = 0;

    // behavioural reference state
    logic m_s1, m_s2, m_stab, m_ovr_en, m_ovr_val, m_req, m_fail, m_host, m_busy, m_applied;
    int   m_cnt, m_deb;

    always #5 clk = ~clk;

    usb_role_ctrl u_dut (
        .clk(clk), .rst(rst), .id_pin_i(id_pin), .bus_idle_i(idle),
        .nego_done_i(done), .nego_ok_i(ok), .reg_addr_i(addr), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .is_host_o(is_host), .nego_busy_o(busy)
    );

    function automatic logic [7:0] m_read(logic [1:0] a);
        case (a)
            2'd0: return {5'd0, m_req, m_ovr_val, m_ovr_en};
            2'd1: return {4'd0, m_stab, m_fail, m_busy, m_host};
            2'd2: return 8'(m_deb);
            default: return 8'd0;
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        logic eff, n_stab, n_host, n_busy, n_applied, n_req, n_fail, clr, fset;
        int n_cnt;
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_stab = 1; m_cnt = 0; m_deb = 4;
            m_ovr_en = 0; m_ovr_val = 0; m_req = 0; m_fail = 0;
            m_host = 0; m_busy = 0; m_applied = 1;
        end else begin
            eff = m_ovr_en ? m_ovr_val : m_stab;
            n_stab = m_stab; n_cnt = m_cnt;
            if (m_s2 == m_stab) n_cnt = 0;
            else if (m_cnt + 1 >= m_deb) begin n_stab = m_s2; n_cnt = 0; end
            else n_cnt = m_cnt + 1;
            n_host = m_host; n_busy = m_busy; n_applied = m_applied; clr = 0; fset = 0;
            if (!m_busy) begin
                if (eff != m_applied && idle) begin n_host = !eff; n_applied = eff; end
                else if (m_req && idle) begin
                    if (m_host) clr = 1; else n_busy = 1;
                end
            end else if (done) begin
                if (ok) n_host = 1; else fset = 1;
                clr = 1; n_busy = 0;
            end
            n_req = m_req; n_fail = m_fail;
            if (clr) n_req = 0; else if (wr && addr == 0 && wdata[2]) n_req = 1;
            if (fset) n_fail = 1; else if (wr && addr == 1 && wdata[2]) n_fail = 0;
            if (wr && addr == 0) begin m_ovr_en = wdata[0]; m_ovr_val = wdata[1]; end
            if (wr && addr == 2) m_deb = int'(wdata);
            m_s2 = m_s1; m_s1 = id_pin;
            m_stab = n_stab; m_cnt = n_cnt; m_host = n_host; m_busy = n_busy;
            m_applied = n_applied; m_req = n_req; m_fail = n_fail;
        end
        #2;
        check("R2 role vs model", {7'd0, is_host}, {7'd0, m_host});
        check("R6 busy vs model", {7'd0, busy}, {7'd0, m_busy});
        check("R10 rdata vs model", rdata, m_read(addr));
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(logic [1:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1;
        @(negedge clk); wr = 0;
    endtask

    task automatic rchk(string req, logic [1:0] a, logic [7:0] exp);
        @(negedge clk); addr = a; #1;
        check(req, rdata, exp);
    endtask

    task automatic pulse_done(logic res);
        @(negedge clk); done = 1; ok = res;
        @(negedge clk); done = 0; ok = 0;
    endtask

    initial begin
        cyc(3); rst = 0;
        // R1 reset state
        rchk("R1 ctrl", 2'd0, 8'h00);
        rchk("R1 stat", 2'd1, 8'h08);
        rchk("R1 deb", 2'd2, 8'd4);
        // R2 pin low -> host
        id_pin = 0; cyc(12);
        rchk("R2 host from low pin", 2'd1, 8'h01);
        // R3 short high glitch ignored
        id_pin = 1; cyc(2); id_pin = 0; cyc(10);
        rchk("R3 glitch ignored", 2'd1, 8'h01);
        id_pin = 1; cyc(12);
        rchk("R2 device from high pin", 2'd1, 8'h08);
        // R5 deferred while busy bus
        idle = 0; id_pin = 0; cyc(14);
        rchk("R5 deferred, filtered low", 2'd1, 8'h00);
        idle = 1; cyc(2);
        rchk("R5 applied at idle", 2'd1, 8'h01);
        // R4 override
        wreg(2'd0, 8'h03); cyc(2);
        rchk("R4 override to device", 2'd1, 8'h00);
        id_pin = 1; cyc(12); id_pin = 0; cyc(12);
        rchk("R4 pin ignored under override", 2'd1, 8'h00);
        wreg(2'd0, 8'h01); cyc(2);
        rchk("R4 override to host", 2'd1, 8'h01);
        wreg(2'd0, 8'h00); id_pin = 1; cyc(12);
        rchk("R2 back to device", 2'd1, 8'h08);
        // R6/R8 request waits for idle, then fails
        idle = 0; wreg(2'd0, 8'h04); cyc(4);
        rchk("R6 request pending, no busy", 2'd0, 8'h04);
        idle = 1; cyc(2);
        check("R6 busy at idle", {7'd0, busy}, 8'd1);
        pulse_done(0); cyc(1);
        rchk("R8 fail flag, role kept", 2'd1, 8'h0C);
        rchk("R8 request cleared", 2'd0, 8'h00);
        wreg(2'd2, 8'd6); cyc(3);
        rchk("R8 flag sticky", 2'd1, 8'h0C);
        wreg(2'd1, 8'h04); cyc(1);
        rchk("R8 flag cleared", 2'd1, 8'h08);
        // R7 success
        wreg(2'd0, 8'h04); cyc(2);
        pulse_done(1); cyc(1);
        rchk("R7 host after success", 2'd1, 8'h09);
        rchk("R7 request cleared", 2'd0, 8'h00);
        // R9 request while host dropped
        wreg(2'd0, 8'h04); cyc(3);
        rchk("R9 request dropped", 2'd0, 8'h00);
        check("R9 no negotiation", {7'd0, busy}, 8'd0);
        // R3 longer debounce: 5 cycles low with length 6 ignored
        id_pin = 0; cyc(5); id_pin = 1; cyc(10);
        rchk("R3 below programmed length", 2'd1, 8'h09);
        rchk("R10 reserved", 2'd3, 8'h00);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule